// File: doc/BRIEF.md
# Receive Interrupt Coalescing Timer

This block holds back receive-timer interrupts so that one interrupt can cover a burst of received packets. Every time a packet has landed in system memory, a countdown starts at a programmed delay. A packet that arrives before the countdown ends restarts it at the full delay. When the countdown runs out, the block raises a one-cycle flush request for pending receive descriptor writebacks and, in the same cycle, a one-cycle receive-timer interrupt cause pulse.

The countdown moves only on a prescaled time-base tick. A delay of zero switches coalescing off, so every packet is reported at once. Software can force an immediate expiry by writing the register with the flush bit set. An expiry pulse from a separate absolute timer cancels whatever this timer has pending. The counter is then left reloaded but halted until the next packet arrives.

The block has no data stream, so every pin is a plain control or status pin. The write port is a single strobe with its data, and it accepts a write on every cycle. The readback is combinational.

Top module: `rx_coalesce_timer`

## Requirements
- R1: After reset, `flush_req` and `rx_tmr_irq` are low, and `cfg_rd_data` reads zero.
- R2: Bits [15:0] of `cfg_rd_data` return the delay last written through `cfg_wr_data[15:0]`. Bit 16 is the force-flush bit, and it always reads 0.
- R3: Take a packet pulse with a delay D > 0 and no later packet. The pulse on `flush_req` and `rx_tmr_irq` comes in the cycle right after the clock edge that samples the D-th tick following the packet. Cycles without `tick` do not advance the count. Both outputs are high for that one cycle only.
- R4: A packet that arrives before expiry reloads the count to D. No pulse comes until D further ticks have been sampled.
- R5: With a delay of 0, each packet gives a pulse in the cycle right after it. Back-to-back packets give back-to-back pulses.
- R6: A write with bit 16 set gives a pulse in the cycle right after the write, whatever the timer's state. If no packet arrives in that cycle, the countdown then halts.
- R7: An absolute-timer pulse cancels a running countdown, so no pulse follows from it. This also holds when the absolute-timer pulse comes in the same cycle as the expiring tick.
- R8: After a cancellation, a new packet restarts a full countdown of D ticks.
- R9: If a packet arrives in the same cycle as an expiry, the pulse still comes. The packet then starts a fresh countdown of D ticks.
- R10: While the timer is halted and nothing is pending, ticks produce no pulse.
- R11: Writing a new delay during a countdown does not change the count in progress. The new value applies from the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 17 | Write data: [15:0] delay in ticks, [16] force flush |
| cfg_rd_data | output | 17 | Readback: [15:0] delay, [16] always 0 |
| pkt_done | input | 1 | Pulse: one received packet reached system memory |
| abs_expire | input | 1 | Pulse: absolute timer expired |
| tick | input | 1 | Prescaled time-base tick |
| flush_req | output | 1 | One-cycle request to flush pending descriptor writebacks |
| rx_tmr_irq | output | 1 | One-cycle receive-timer interrupt cause |

## Verification
The assertions assume that `pkt_done`, `abs_expire` and `tick` are clean, synchronous, single-cycle-sampled levels. They also assume the inputs never go to X outside reset. The bench drives every input on the falling edge and clears each strobe after a single cycle, so every event is seen at exactly one rising edge. Collisions such as packet-with-expiry and absolute-timer-with-expiry are created on purpose by placing both strobes in the same driven cycle. The bench never relies on skew between them.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

  // Reasons a flush/interrupt pulse is issued in a cycle
  typedef struct packed {
    logic forced;   // software force-flush write
    logic expired;  // countdown reached its end on a tick
    logic bypass;   // zero delay: packet reported at once
  } rxc_fire_t;

  // Counter update chosen each cycle
  typedef enum logic [1:0] {
    RXC_HOLD      = 2'd0,
    RXC_LOAD_RUN  = 2'd1,
    RXC_LOAD_HALT = 2'd2,
    RXC_DEC       = 2'd3
  } rxc_cnt_op_e;

endpackage

// File: rtl/rxc_cfg_reg.sv
module rxc_cfg_reg #(
  parameter int unsigned DLY_W = 16,
  localparam int unsigned REG_W = DLY_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [DLY_W-1:0] dly,
  output logic             force_flush,
  output logic [REG_W-1:0] rd_data
);

  logic [DLY_W-1:0] dly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dly_q <= '0;
    else if (wr_en) dly_q <= wr_data[DLY_W-1:0];
  end

  // force bit is a strobe only: it is never stored
  assign force_flush = wr_en & wr_data[DLY_W];
  assign dly         = dly_q;
  assign rd_data     = {1'b0, dly_q};

endmodule

// File: rtl/rxc_countdown.sv
module rxc_countdown
  import rxc_pkg::*;
#(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DLY_W-1:0] dly,
  input  logic             pkt_done,
  input  logic             tick,
  input  logic             abs_expire,
  input  logic             force_flush,
  output logic             expire_now,
  output logic             running,
  output logic [DLY_W-1:0] cnt
);

  localparam logic [DLY_W-1:0] LAST = DLY_W'(1);

  logic        zero_dly;
  rxc_cnt_op_e op;

  assign zero_dly = (dly == '0);

  // cancellation by the absolute timer suppresses a same-cycle expiry
  assign expire_now = running & tick & (cnt == LAST) & ~abs_expire;

  always_comb begin
    if (abs_expire)
      op = RXC_LOAD_HALT;
    else if (expire_now || force_flush)
      op = (pkt_done && !zero_dly) ? RXC_LOAD_RUN : RXC_LOAD_HALT;
    else if (pkt_done)
      op = zero_dly ? RXC_LOAD_HALT : RXC_LOAD_RUN;
    else if (running && tick)
      op = RXC_DEC;
    else
      op = RXC_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
    end else begin
      unique case (op)
        RXC_LOAD_RUN:  begin cnt <= dly;      running <= 1'b1; end
        RXC_LOAD_HALT: begin cnt <= dly;      running <= 1'b0; end
        RXC_DEC:       begin cnt <= cnt - LAST;                end
        default:       begin                                   end
      endcase
    end
  end

endmodule

// File: rtl/rxc_irq_out.sv
module rxc_irq_out
  import rxc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  rxc_fire_t fire,
  output logic      flush_req,
  output logic      rx_tmr_irq
);

  logic fire_any;
  assign fire_any = |fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_req  <= 1'b0;
      rx_tmr_irq <= 1'b0;
    end else begin
      flush_req  <= fire_any;
      rx_tmr_irq <= fire_any;
    end
  end

endmodule

// File: rtl/rx_coalesce_timer.sv
module rx_coalesce_timer
  import rxc_pkg::*;
#(
  parameter int unsigned DLY_W = 16,
  localparam int unsigned REG_W = DLY_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [REG_W-1:0] cfg_wr_data,
  output logic [REG_W-1:0] cfg_rd_data,
  input  logic             pkt_done,
  input  logic             abs_expire,
  input  logic             tick,
  output logic             flush_req,
  output logic             rx_tmr_irq
);

  logic [DLY_W-1:0] dly;
  logic             force_flush;
  logic             expire_now;
  logic             running;
  logic [DLY_W-1:0] cnt;
  rxc_fire_t        fire;

  rxc_cfg_reg #(.DLY_W(DLY_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_wr_en),
    .wr_data    (cfg_wr_data),
    .dly        (dly),
    .force_flush(force_flush),
    .rd_data    (cfg_rd_data)
  );

  rxc_countdown #(.DLY_W(DLY_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .dly        (dly),
    .pkt_done   (pkt_done),
    .tick       (tick),
    .abs_expire (abs_expire),
    .force_flush(force_flush),
    .expire_now (expire_now),
    .running    (running),
    .cnt        (cnt)
  );

  assign fire.forced  = force_flush;
  assign fire.expired = expire_now;
  assign fire.bypass  = pkt_done & (dly == '0);

  rxc_irq_out u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .flush_req (flush_req),
    .rx_tmr_irq(rx_tmr_irq)
  );

endmodule

// File: rtl/rxc_checker.sv
module rxc_checker #(
  parameter int unsigned DLY_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [DLY_W-1:0] wr_dly,
  input logic             wr_ff,
  input logic [DLY_W-1:0] rd_dly,
  input logic             rd_ff,
  input logic             pkt_done,
  input logic             abs_expire,
  input logic             tick,
  input logic             rx_tmr_irq,
  input logic             running,
  input logic [DLY_W-1:0] cnt
);

  p_rdback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_dly == $past(wr_dly));

  p_ff_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ff);

  p_run_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> cnt != '0);

  p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !tick && !pkt_done && !abs_expire && !(wr_en && wr_ff))
      |=> $stable(cnt) && running);

  p_zero_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && rd_dly == '0) |=> rx_tmr_irq);

  p_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ff) |=> rx_tmr_irq);

  p_abs_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abs_expire |=> !running);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !pkt_done && !(wr_en && wr_ff)) |=> !rx_tmr_irq);

endmodule

bind rx_coalesce_timer rxc_checker #(.DLY_W(DLY_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (cfg_wr_en),
  .wr_dly    (cfg_wr_data[DLY_W-1:0]),
  .wr_ff     (cfg_wr_data[DLY_W]),
  .rd_dly    (cfg_rd_data[DLY_W-1:0]),
  .rd_ff     (cfg_rd_data[DLY_W]),
  .pkt_done  (pkt_done),
  .abs_expire(abs_expire),
  .tick      (tick),
  .rx_tmr_irq(rx_tmr_irq),
  .running   (running),
  .cnt       (cnt)
);

// File: tb/rx_coalesce_timer_tb.sv
module rx_coalesce_timer_tb;

  localparam int unsigned DW = 16;
  localparam int unsigned RW = DW + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr_en = 1'b0;
  logic [RW-1:0] cfg_wr_data = '0;
  logic [RW-1:0] cfg_rd_data;
  logic          pkt_done = 1'b0;
  logic          abs_expire = 1'b0;
  logic          tick = 1'b0;
  logic          flush_req;
  logic          rx_tmr_irq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  rx_coalesce_timer #(.DLY_W(DW)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr_en  (cfg_wr_en),
    .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data),
    .pkt_done   (pkt_done),
    .abs_expire (abs_expire),
    .tick       (tick),
    .flush_req  (flush_req),
    .rx_tmr_irq (rx_tmr_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle of stimulus; returns the pulse seen after that edge
  task automatic step(input logic p, input logic t, input logic a,
                      input logic w, input logic [RW-1:0] d, output logic pulse);
    pkt_done = p; tick = t; abs_expire = a; cfg_wr_en = w; cfg_wr_data = d;
    @(posedge clk);
    @(negedge clk);
    pulse = rx_tmr_irq;
    if (flush_req !== rx_tmr_irq) begin
      checks++; fails++;
      $display("FAIL R3 flush/irq mismatch: actual=%b expected=%b", flush_req, rx_tmr_irq);
    end
    pkt_done = 1'b0; tick = 1'b0; abs_expire = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = '0;
  endtask

  task automatic set_delay(input logic [DW-1:0] v);
    logic q;
    step(0, 0, 0, 1, {1'b0, v}, q);
  endtask

  task automatic ticks_quiet(input int n, input string req);
    logic q;
    for (int i = 0; i < n; i++) begin
      step(0, 1, 0, 0, '0, q);
      chk(req, q, 0);
    end
  endtask

  task automatic t_reset;
    chk("R1 irq", rx_tmr_irq, 0);
    chk("R1 flush", flush_req, 0);
    chk("R1 readback", cfg_rd_data, 0);
  endtask

  task automatic t_regs;
    logic q;
    step(0, 0, 0, 1, 17'h1_0005, q);
    chk("R6 force while idle", q, 1);
    chk("R2 delay readback", cfg_rd_data, 32'h5);
    step(0, 0, 0, 1, 17'h0_ABCD, q);
    chk("R2 full field, bit16 zero", cfg_rd_data, 32'hABCD);
  endtask

  task automatic t_countdown;
    logic q;
    set_delay(3);
    step(1, 0, 0, 0, '0, q); chk("R3 no pulse on packet", q, 0);
    for (int i = 0; i < 5; i++) begin
      step(0, 0, 0, 0, '0, q); chk("R3 no tick no count", q, 0);
    end
    ticks_quiet(2, "R3 before D-th tick");
    step(0, 1, 0, 0, '0, q); chk("R3 pulse on D-th tick", q, 1);
    ticks_quiet(4, "R10 idle ticks after expiry");
  endtask

  task automatic t_retrigger;
    logic q;
    set_delay(3);
    step(1, 0, 0, 0, '0, q);
    ticks_quiet(2, "R4 first run");
    step(1, 0, 0, 0, '0, q); chk("R4 reload packet", q, 0);
    ticks_quiet(2, "R4 after reload");
    step(0, 1, 0, 0, '0, q); chk("R4 pulse after full reload", q, 1);
  endtask

  task automatic t_zero;
    logic q;
    set_delay(0);
    step(1, 0, 0, 0, '0, q); chk("R5 immediate pulse", q, 1);
    step(1, 0, 0, 0, '0, q); chk("R5 back-to-back pulse", q, 1);
    ticks_quiet(3, "R5 no later pulse");
  endtask

  task automatic t_force;
    logic q;
    set_delay(3);
    step(1, 0, 0, 0, '0, q);
    step(0, 1, 0, 0, '0, q);
    step(0, 0, 0, 1, 17'h1_0003, q); chk("R6 force mid-countdown", q, 1);
    chk("R2 force bit not stored", cfg_rd_data, 32'h3);
    ticks_quiet(4, "R6 halted after force");
  endtask

  task automatic t_abs;
    logic q;
    set_delay(3);
    step(1, 0, 0, 0, '0, q);
    step(0, 1, 0, 0, '0, q);
    step(0, 0, 1, 0, '0, q); chk("R7 cancel", q, 0);
    ticks_quiet(5, "R7 halted after cancel");
    step(1, 0, 0, 0, '0, q);
    ticks_quiet(2, "R8 restart counting");
    step(0, 1, 0, 0, '0, q); chk("R8 full countdown after restart", q, 1);
    step(1, 0, 0, 0, '0, q);
    ticks_quiet(2, "R7 before collision");
    step(0, 1, 1, 0, '0, q); chk("R7 cancel beats expiry", q, 0);
    ticks_quiet(4, "R7 quiet after collision");
  endtask

  task automatic t_collide;
    logic q;
    set_delay(3);
    step(1, 0, 0, 0, '0, q);
    ticks_quiet(2, "R9 first run");
    step(1, 1, 0, 0, '0, q); chk("R9 expiry wins", q, 1);
    ticks_quiet(2, "R9 fresh countdown");
    step(0, 1, 0, 0, '0, q); chk("R9 second pulse", q, 1);
  endtask

  task automatic t_delay_change;
    logic q;
    set_delay(4);
    step(1, 0, 0, 0, '0, q);
    step(0, 1, 0, 0, '0, q);
    set_delay(2);
    ticks_quiet(2, "R11 old count kept");
    step(0, 1, 0, 0, '0, q); chk("R11 expiry on old count", q, 1);
    step(1, 0, 0, 0, '0, q);
    ticks_quiet(1, "R11 new delay");
    step(0, 1, 0, 0, '0, q); chk("R11 new delay applied", q, 1);
  endtask

  initial begin
    #(4 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_countdown();
    t_retrigger();
    t_zero();
    t_force();
    t_abs();
    t_collide();
    t_delay_change();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule